// File: doc/BRIEF.md
# Serial Peripheral Host with Status and Overrun Flags

This block is a single-select SPI host that moves one data word per transfer. Software loads a word into a transmit holding register. The shift engine picks it up as soon as it is idle and clocks it out most significant bit first in SPI mode 0. At the same time it samples the serial input into a receive holding register.

A status word reports several conditions:
- whether each holding register is free or occupied;
- whether the shifter is idle;
- two overrun conditions, one for each direction;
- an end-of-packet flag, raised when a data word matches a programmable compare value.

An enable mask selects which status conditions drive the single interrupt output.

The two overrun rules differ. A word that completes reception while the previous one is still unread replaces it. A word written while the transmit holding register is occupied is thrown away.

Register addresses (`reg_addr`): 0 receive data, 1 transmit data, 2 status, 3 interrupt enable, 4 end-of-packet compare value. `reg_rdata` is combinational from `reg_addr`. Read side effects occur at the clock edge where `reg_rd` is high.

Top module: `spi_host_flags`

## Requirements
- R1: After reset the status word reads 0x060 (TMT and TRDY set, all else clear), `spi_ss_n` is 1, `spi_sclk` is 0 and `irq` is 0.
- R2: A word accepted at address 1 is shifted out MSB first in mode 0, with `spi_sclk` idle low and input sampled on its rising edges. `spi_ss_n` is low only for that one word. The sampled word then appears at address 0.
- R3: Status bit 6 (TRDY) is 1 while the transmit holding register is empty. Status bit 5 (TMT) is 0 while a transfer is in progress and 1 otherwise. A write at address 1 while TRDY is 1 is accepted.
- R4: A write at address 1 while TRDY is 0 sets status bit 4 (TOE). The written word is dropped and never transmitted.
- R5: When a transfer completes while status bit 7 (RRDY) is 1, status bit 3 (ROE) is set. The new word replaces the unread word.
- R6: Status bit 8 (E) always equals ROE OR TOE.
- R7: Any write at address 2 clears ROE, TOE, E and EOP, whatever the data written. RRDY, TRDY and TMT are not changed by it.
- R8: Reading status has no side effect. Reading address 0 clears RRDY.
- R9: Status bit 9 (EOP) is set when a read at address 0 returns, or a write at address 1 carries, a word equal to the value at address 4.
- R10: `irq` is the OR over all status bits ANDed with the enable register at address 3, which uses the same bit positions as the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | 1 | Active-low select |

## Verification
A stuck holding-register flag shows up in the status word on the very next register access. It also shows one transfer later as a missing transfer, an extra transfer, or a received word that differs from the one sent. A wrong shift order or a wrong sampling edge corrupts the looped-back word, so the error is visible at address 0 one transfer time, 2·DW·SCLK_DIV cycles, after the write. Faulty overrun, clear or compare logic shows up in the status word and on `irq` within one cycle of the triggering access or transfer completion.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int REG_W = 16;

  localparam logic [2:0] ADDR_RX   = 3'd0;
  localparam logic [2:0] ADDR_TX   = 3'd1;
  localparam logic [2:0] ADDR_STAT = 3'd2;
  localparam logic [2:0] ADDR_IEN  = 3'd3;
  localparam logic [2:0] ADDR_EOPV = 3'd4;

  localparam int BIT_ROE  = 3;
  localparam int BIT_TOE  = 4;
  localparam int BIT_TMT  = 5;
  localparam int BIT_TRDY = 6;
  localparam int BIT_RRDY = 7;
  localparam int BIT_ERR  = 8;
  localparam int BIT_EOP  = 9;

  localparam logic [REG_W-1:0] STAT_MASK = 16'h03F8;

  function automatic logic [REG_W-1:0] build_status(
      input logic roe, input logic toe, input logic tmt,
      input logic trdy, input logic rrdy, input logic eop);
    logic [REG_W-1:0] s;
    s = '0;
    s[BIT_ROE]  = roe;
    s[BIT_TOE]  = toe;
    s[BIT_TMT]  = tmt;
    s[BIT_TRDY] = trdy;
    s[BIT_RRDY] = rrdy;
    s[BIT_ERR]  = roe | toe;
    s[BIT_EOP]  = eop;
    return s;
  endfunction
endpackage

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DW       = 8,
  parameter int SCLK_DIV = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] tx_word,
  input  logic          miso,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_word,
  output logic          sclk,
  output logic          mosi,
  output logic          ss_n
);
  localparam int CW = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;
  localparam int BW = $clog2(DW + 1);

  logic [CW-1:0] div_q;
  logic [BW-1:0] bits_q;
  logic [DW-1:0] tx_sh, rx_sh;
  logic          sclk_q, busy_q, done_q;
  logic          tick;

  assign tick = (div_q == CW'(SCLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      bits_q <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      sclk_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          tx_sh  <= tx_word;
          div_q  <= '0;
          bits_q <= '0;
          sclk_q <= 1'b0;
        end
      end else if (tick) begin
        div_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_sh  <= {rx_sh[DW-2:0], miso};
          bits_q <= bits_q + 1'b1;
        end else begin
          sclk_q <= 1'b0;
          if (bits_q == BW'(DW)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            tx_sh <= {tx_sh[DW-2:0], 1'b0};
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_word = rx_sh;
  assign sclk    = sclk_q;
  assign mosi    = busy_q ? tx_sh[DW-1] : 1'b0;
  assign ss_n    = ~busy_q;
endmodule

// File: rtl/spi_status_core.sv
module spi_status_core #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_wdata,
  input  logic          load,
  input  logic          rx_rd,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_word,
  input  logic          st_wr,
  input  logic [DW-1:0] eop_val,
  output logic          tx_full,
  output logic [DW-1:0] tx_buf,
  output logic          rx_full,
  output logic [DW-1:0] rx_buf,
  output logic          roe,
  output logic          toe,
  output logic          eop
);
  function automatic logic word_match(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a == b;
  endfunction

  logic tx_accept, tx_drop, rx_overrun, eop_hit;

  assign tx_accept  = tx_wr & ~tx_full;
  assign tx_drop    = tx_wr & tx_full;
  assign rx_overrun = rx_done & rx_full;
  assign eop_hit    = (rx_rd & word_match(rx_buf, eop_val)) |
                      (tx_wr & word_match(tx_wdata, eop_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_buf  <= '0;
      rx_full <= 1'b0;
      rx_buf  <= '0;
      roe     <= 1'b0;
      toe     <= 1'b0;
      eop     <= 1'b0;
    end else begin
      if (tx_accept) begin
        tx_full <= 1'b1;
        tx_buf  <= tx_wdata;
      end else if (load) begin
        tx_full <= 1'b0;
      end

      if (rx_done) begin
        rx_buf  <= rx_word;
        rx_full <= 1'b1;
      end else if (rx_rd) begin
        rx_full <= 1'b0;
      end

      if (rx_overrun)  roe <= 1'b1;
      else if (st_wr)  roe <= 1'b0;
      if (tx_drop)     toe <= 1'b1;
      else if (st_wr)  toe <= 1'b0;
      if (eop_hit)     eop <= 1'b1;
      else if (st_wr)  eop <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_host_flags.sv
module spi_host_flags
  import spi_host_pkg::*;
#(
  parameter int DW       = 8,
  parameter int SCLK_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_ss_n
);
  logic          tx_wr, rx_rd, st_wr, ie_wr, ev_wr, stat_rd;
  logic          tx_full, rx_full, roe, toe, eop;
  logic          busy, rx_done, load;
  logic [DW-1:0] tx_buf, rx_buf, rx_word, eop_val;
  logic [15:0]   ie, status;

  assign tx_wr   = reg_wr & (reg_addr == ADDR_TX);
  assign st_wr   = reg_wr & (reg_addr == ADDR_STAT);
  assign ie_wr   = reg_wr & (reg_addr == ADDR_IEN);
  assign ev_wr   = reg_wr & (reg_addr == ADDR_EOPV);
  assign rx_rd   = reg_rd & (reg_addr == ADDR_RX);
  assign stat_rd = reg_rd & (reg_addr == ADDR_STAT);
  assign load    = tx_full & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie      <= '0;
      eop_val <= '0;
    end else begin
      if (ie_wr) ie <= reg_wdata & STAT_MASK;
      if (ev_wr) eop_val <= reg_wdata[DW-1:0];
    end
  end

  spi_status_core #(.DW(DW)) u_status (
    .clk(clk), .rst_n(rst_n),
    .tx_wr(tx_wr), .tx_wdata(reg_wdata[DW-1:0]), .load(load),
    .rx_rd(rx_rd), .rx_done(rx_done), .rx_word(rx_word),
    .st_wr(st_wr), .eop_val(eop_val),
    .tx_full(tx_full), .tx_buf(tx_buf), .rx_full(rx_full), .rx_buf(rx_buf),
    .roe(roe), .toe(toe), .eop(eop)
  );

  spi_shift_engine #(.DW(DW), .SCLK_DIV(SCLK_DIV)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .start(load), .tx_word(tx_buf), .miso(spi_miso),
    .busy(busy), .done(rx_done), .rx_word(rx_word),
    .sclk(spi_sclk), .mosi(spi_mosi), .ss_n(spi_ss_n)
  );

  assign status = build_status(roe, toe, ~busy, ~tx_full, rx_full, eop);
  assign irq    = |(status & ie);

  always_comb begin
    case (reg_addr)
      ADDR_RX:   reg_rdata = 16'(rx_buf);
      ADDR_STAT: reg_rdata = status;
      ADDR_IEN:  reg_rdata = ie;
      ADDR_EOPV: reg_rdata = 16'(eop_val);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_host_flags_chk.sv
module spi_host_flags_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_wr,
  input logic        tx_full,
  input logic        busy,
  input logic        rx_done,
  input logic        rx_full,
  input logic        rx_rd,
  input logic        st_wr,
  input logic        stat_rd,
  input logic        roe,
  input logic        toe,
  input logic        eop,
  input logic        sclk,
  input logic        ss_n,
  input logic        irq,
  input logic [15:0] ie
);
  a_r4_toe_drop: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr && tx_full && busy |=> toe && tx_full);

  a_r5_roe_replace: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_full |=> roe && rx_full);

  a_r7_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr && !tx_wr && !rx_done |=> !roe && !toe);

  a_r2_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> !sclk);

  a_r8_read_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !tx_wr && !rx_done && !st_wr && !rx_rd |=>
      $stable(roe) && $stable(toe) && $stable(eop) && $stable(rx_full));

  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ie == 16'h0) |-> !irq);

  a_r3_busy_select: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !ss_n);
endmodule

bind spi_host_flags spi_host_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_full(tx_full), .busy(busy),
  .rx_done(rx_done), .rx_full(rx_full), .rx_rd(rx_rd), .st_wr(st_wr),
  .stat_rd(stat_rd), .roe(roe), .toe(toe), .eop(eop), .sclk(spi_sclk),
  .ss_n(spi_ss_n), .irq(irq), .ie(ie)
);

// File: tb/tb_spi_host_flags.sv
module tb_spi_host_flags;
  localparam int CLK_P = 10;
  localparam logic [7:0] EOPV = 8'h7E;
  localparam int NV = 6;
  localparam logic [8:0] VEC [NV] = '{
    {1'b0, 8'hA5}, {1'b0, 8'h3C}, {1'b1, 8'h7E},
    {1'b0, 8'h01}, {1'b0, 8'h80}, {1'b0, 8'hFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq, spi_sclk, spi_mosi, spi_miso, spi_ss_n;
  logic [7:0]  cap = '0;
  int          total = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;
  assign spi_miso = spi_mosi;
  always @(posedge spi_sclk) cap <= {cap[6:0], spi_mosi};

  spi_host_flags dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_ss_n(spi_ss_n)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 1000; i++) begin
      rd_reg(3'd2, s);
      if (s[5] && s[6]) return;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] d, s1;
    #(CLK_P * 3);
    rst_n = 1'b1;
    rd_reg(3'd2, d);
    check("R1 status", d, 16'h0060);
    check("R1 pins", {13'b0, spi_ss_n, spi_sclk, irq}, 16'h0004);

    wr_reg(3'd4, {8'h00, EOPV});
    for (int i = 0; i < NV; i++) begin
      wr_reg(3'd2, 16'h0000);
      wr_reg(3'd1, {8'h00, VEC[i][7:0]});
      wait_idle();
      check("R2 mosi order", {8'h00, cap}, {8'h00, VEC[i][7:0]});
      rd_reg(3'd0, d);
      check("R2 rx word", d, {8'h00, VEC[i][7:0]});
      rd_reg(3'd2, d);
      check("R8 R9 status after rx read", d, 16'h0060 | {6'b0, VEC[i][8], 9'b0});
      check("R2 select idle", {15'b0, spi_ss_n}, 16'h0001);
    end

    // R5 receive overrun: second word replaces first
    wr_reg(3'd2, 16'h0000);
    wr_reg(3'd1, 16'h0011);
    wait_idle();
    wr_reg(3'd1, 16'h0022);
    wait_idle();
    rd_reg(3'd2, d);
    check("R5 R6 roe status", d, 16'h01E8);
    rd_reg(3'd2, s1);
    check("R8 status reread stable", s1, 16'h01E8);
    wr_reg(3'd3, 16'h0008);
    #1 check("R10 irq roe enabled", {15'b0, irq}, 16'h0001);
    wr_reg(3'd3, 16'h0010);
    #1 check("R10 irq toe only", {15'b0, irq}, 16'h0000);
    wr_reg(3'd2, 16'hFFFF);
    rd_reg(3'd2, d);
    check("R7 clear keeps rrdy", d, 16'h00E0);
    rd_reg(3'd0, d);
    check("R5 newest word kept", d, 16'h0022);

    // R4 transmit overrun: third word dropped
    wr_reg(3'd1, 16'h0033);
    wr_reg(3'd1, 16'h0044);
    wr_reg(3'd1, 16'h0055);
    rd_reg(3'd2, d);
    check("R4 R3 toe busy status", d, 16'h0110);
    #1 check("R10 irq toe enabled", {15'b0, irq}, 16'h0001);
    wait_idle();
    rd_reg(3'd0, d);
    check("R4 second word received", d, 16'h0044);
    repeat (100) @(negedge clk);
    rd_reg(3'd2, d);
    check("R4 dropped word never sent", d, 16'h0178);
    wr_reg(3'd2, 16'h1234);
    rd_reg(3'd2, d);
    check("R7 any data clears", d, 16'h0060);
    #1 check("R6 irq after clear", {15'b0, irq}, 16'h0000);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule